// File: doc/BRIEF.md
# Prescaled Dequantization Table Unit

This block keeps the 64-entry quantization table of an 8x8 coefficient block and folds the output scaling of a scaled inverse transform into that table. Software, or an upstream parser, first writes the raw table entries. It then issues a start request. The block walks all 64 positions, one per cycle. At each position it multiplies the raw entry by the product of a row factor and a column factor and stores the rounded result, which keeps eight extra fractional bits. The transform constants are therefore applied once per table rather than once per coefficient, and the downstream transform needs fewer multiplies in each 1-D pass.

During decoding, parsed coefficients arrive on a valid/ready stream. Each carries an index that is either a zigzag scan position or a natural raster position. The block converts the index to natural order, multiplies the coefficient by the prescaled entry at that position, rounds, saturates to 16 signed bits, and presents the result together with its natural index on an output valid/ready stream.

A table load or a prescale never breaks into a block that is partly received. Loads are refused until the 64th coefficient of the block is taken. A start that arrives mid-block is held and runs at the next block boundary.

Top module: `dq_prescale_table`

## Requirements
- R1: A table write is accepted in a cycle where `ld_valid` and `ld_ready` are both high. It stores `ld_q` as the raw entry at natural position `ld_addr`, where row = `ld_addr[5:3]` and column = `ld_addr[2:0]`. A write changes no prescaled entry until the next prescale pass.
- R2: A start taken at a block boundary holds `in_ready` and `ld_ready` low for 65 consecutive cycles: the cycle in which it is taken, plus 64 prescale cycles. `done` is high for exactly one cycle, the first cycle after those 65, and is low at all other times.
- R3: Prescaled entry P(n) = floor((q(n) * F[row] * F[col] + 2^19) / 2^20), where q(n) is the raw entry at n. The factor F[0..7] = 16384, 22725, 21407, 19266, 16384, 12873, 8867, 4520 (Q1.14).
- R4: A coefficient c accepted at natural position n produces `out_coef` = sat(floor((c * P(n) + 128) / 256)) and `out_idx` = n. The result is registered in the accepting clock edge.
- R5: When `in_zz` is 1, `in_idx` is a zigzag scan position. Position 0 maps to (0,0) and position 1 maps to (0,1). Each anti-diagonal s = row+col is walked with the row decreasing for even s and increasing for odd s. When `in_zz` is 0, `in_idx` is already natural.
- R6: Results outside [-32768, 32767] are clamped to the nearest limit.
- R7: While 1 to 63 coefficients of the current block have been accepted, `ld_ready` stays low.
- R8: A start that arrives while a block is partly received is remembered. The prescale begins in the cycle after the 64th coefficient is accepted. That 64th coefficient, and every coefficient before it, use the previous prescaled entries.
- R9: A start request while a prescale pass is running has no effect: no second pass and no second `done`.
- R10: Each accepted coefficient yields exactly one output beat, in order. While `out_valid` is high and `out_ready` is low, `out_coef` and `out_idx` hold their values.
- R11: After reset, `out_valid` and `done` are low, `in_ready` and `ld_ready` are high, and the block position count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Raw table write request |
| ld_ready | output | 1 | Table write can be accepted |
| ld_addr | input | 6 | Natural position of the table write |
| ld_q | input | Q_W (8) | Raw quantization value |
| start_req | input | 1 | Request a prescale pass |
| done | output | 1 | One-cycle pulse at the end of a prescale pass |
| in_valid | input | 1 | Coefficient beat valid |
| in_ready | output | 1 | Coefficient beat can be accepted |
| in_zz | input | 1 | 1: in_idx is a zigzag position; 0: natural |
| in_idx | input | 6 | Coefficient position |
| in_coef | input | COEF_W (12) | Signed parsed coefficient |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream takes the result |
| out_idx | output | 6 | Natural position of the result |
| out_coef | output | OUT_W (16) | Signed dequantized, prescaled coefficient |

## Verification
Two functions can coincide in the same cycle. One is the acceptance of the last coefficient of a block. The other is a request that changes the table: a start pulse, or a pending table write. The bench raises `start_req` on exactly the beat that carries the 64th coefficient. It checks that this beat still comes out scaled by the old entries, that the prescale pass follows and pulses `done`, and that the next block comes out scaled by the freshly loaded table. A table write held against a half-received block is judged at the port, by `ld_ready` remaining low until the block closes.

// File: rtl/dqt_pkg.sv
// Shared constants and elaboration-time helpers for the prescaled
// dequantization table. Assumes an 8x8 block (64 positions).
package dqt_pkg;
    localparam int NPOS   = 64;
    localparam int IDX_W  = 6;
    localparam int AX_W   = 3;
    localparam int F_W    = 15;
    localparam int F_FRAC = 14;

    // Per-axis scale factor of the scaled inverse transform, Q1.14.
    function automatic logic [F_W-1:0] axis_factor(input logic [AX_W-1:0] k);
        case (k)
            3'd0:    return 15'd16384;
            3'd1:    return 15'd22725;
            3'd2:    return 15'd21407;
            3'd3:    return 15'd19266;
            3'd4:    return 15'd16384;
            3'd5:    return 15'd12873;
            3'd6:    return 15'd8867;
            default: return 15'd4520;
        endcase
    endfunction

    // Builds the zigzag-to-natural map by walking the scan path step by step.
    function automatic logic [NPOS*IDX_W-1:0] zz_build();
        logic [NPOS*IDX_W-1:0] m;
        int r;
        int c;
        bit up;
        m  = '0;
        r  = 0;
        c  = 0;
        up = 1'b1;
        for (int i = 0; i < NPOS; i++) begin
            m[i*IDX_W +: IDX_W] = IDX_W'(r * 8 + c);
            if (up) begin
                if (c == 7)      begin r = r + 1; up = 1'b0; end
                else if (r == 0) begin c = c + 1; up = 1'b0; end
                else             begin r = r - 1; c = c + 1; end
            end else begin
                if (r == 7)      begin c = c + 1; up = 1'b1; end
                else if (c == 0) begin r = r + 1; up = 1'b1; end
                else             begin r = r + 1; c = c - 1; end
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/dq_index_map.sv
// Converts a coefficient index to natural raster order.
// Assumes: zz=1 means idx is a zigzag scan position, zz=0 means natural.
module dq_index_map import dqt_pkg::*; (
    input  logic             zz,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nat
);
    localparam logic [NPOS*IDX_W-1:0] ZZ_MAP = zz_build();

    // Select mapped or pass-through index.
    always_comb begin
        nat = zz ? ZZ_MAP[int'(idx)*IDX_W +: IDX_W] : idx;
    end
endmodule

// File: rtl/dq_prescale_dp.sv
// Folds the row and column transform factors into one raw table entry.
// Assumes the factors are below 2.0, so the result needs Q_W+2 integer bits.
module dq_prescale_dp import dqt_pkg::*; #(
    parameter int Q_W    = 8,
    parameter int FRAC_X = 8,
    parameter int PS_W   = Q_W + 2 + FRAC_X
)(
    input  logic [Q_W-1:0]  q,
    input  logic [AX_W-1:0] row,
    input  logic [AX_W-1:0] col,
    output logic [PS_W-1:0] ps
);
    localparam int SH  = 2 * F_FRAC - FRAC_X;
    localparam int P_W = Q_W + 2 * F_W;

    logic [F_W-1:0] f_row;
    logic [F_W-1:0] f_col;
    logic [P_W-1:0] prod;
    logic [P_W-1:0] rnd;

    // Triple product, round to nearest at the kept fraction, truncate width.
    always_comb begin
        f_row = axis_factor(row);
        f_col = axis_factor(col);
        prod  = P_W'(q) * P_W'(f_row) * P_W'(f_col);
        rnd   = prod + (P_W'(1) << (SH - 1));
        ps    = PS_W'(rnd >> SH);
    end
endmodule

// File: rtl/dq_coef_mul.sv
// Multiplies a signed coefficient by a prescaled entry, rounds away the
// extra fraction (half rounds up) and saturates to OUT_W signed bits.
module dq_coef_mul #(
    parameter int COEF_W = 12,
    parameter int PS_W   = 18,
    parameter int FRAC_X = 8,
    parameter int OUT_W  = 16
)(
    input  logic signed [COEF_W-1:0] coef,
    input  logic        [PS_W-1:0]   ps,
    output logic signed [OUT_W-1:0]  res
);
    localparam int M_W = COEF_W + PS_W + 1;
    localparam logic signed [M_W-1:0] HI = M_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [M_W-1:0] LO = ~HI;

    logic signed [M_W-1:0] a;
    logic signed [M_W-1:0] b;
    logic signed [M_W-1:0] prod;
    logic signed [M_W-1:0] shf;

    // Signed multiply, round, arithmetic shift, clamp.
    always_comb begin
        a    = M_W'(coef);
        b    = M_W'(ps);
        prod = a * b;
        shf  = (prod + (M_W'(1) <<< (FRAC_X - 1))) >>> FRAC_X;
        if (shf > HI)      res = OUT_W'(HI);
        else if (shf < LO) res = OUT_W'(LO);
        else               res = OUT_W'(shf);
    end
endmodule

// File: rtl/dq_prescale_ctl.sv
// Sequences a prescale pass: one table position per cycle, then a done pulse.
// Assumes blk_open is high while a coefficient block is partly received;
// a start seen then is held until the block closes.
module dq_prescale_ctl import dqt_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             blk_open,
    output logic             go,
    output logic             busy,
    output logic             pend,
    output logic             done,
    output logic [IDX_W-1:0] wr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPOS - 1);

    logic             busy_q;
    logic             pend_q;
    logic             done_q;
    logic [IDX_W-1:0] cnt_q;

    // A pass launches at a block boundary when a start is present or held.
    assign go     = (pend_q | start_req) & ~busy_q & ~blk_open;
    assign busy   = busy_q;
    assign pend   = pend_q;
    assign done   = done_q;
    assign wr_idx = cnt_q;

    // Pass state: launch, step through positions, finish with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                busy_q <= 1'b1;
                pend_q <= 1'b0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (start_req) begin
                pend_q <= 1'b1;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R2
    AST_DONE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q)); // R2
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_req) |=> !pend_q); // R9
endmodule

// File: rtl/dq_prescale_table.sv
// Prescaled dequantization table: raw table storage, a prescale pass that
// folds transform factors into a second table, and a coefficient stream
// that is multiplied by the prescaled entry for its position.
// Assumes each start follows a complete raw table load.
module dq_prescale_table import dqt_pkg::*; #(
    parameter int COEF_W = 12,
    parameter int Q_W    = 8,
    parameter int FRAC_X = 8,
    parameter int OUT_W  = 16
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    output logic                     ld_ready,
    input  logic [IDX_W-1:0]         ld_addr,
    input  logic [Q_W-1:0]           ld_q,
    input  logic                     start_req,
    output logic                     done,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_zz,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic signed [COEF_W-1:0] in_coef,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [IDX_W-1:0]         out_idx,
    output logic signed [OUT_W-1:0]  out_coef
);
    localparam int PS_W = Q_W + 2 + FRAC_X;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPOS - 1);

    logic [Q_W-1:0]   raw_tab [NPOS];
    logic [PS_W-1:0]  ps_tab  [NPOS];
    logic [IDX_W-1:0] blk_cnt;
    logic             blk_open;
    logic             go;
    logic             busy;
    logic             pend;
    logic [IDX_W-1:0] wr_idx;
    logic [PS_W-1:0]  ps_new;
    logic [IDX_W-1:0] nat_idx;
    logic signed [OUT_W-1:0] mul_res;
    logic             in_acc;
    logic             ld_acc;
    logic             out_valid_q;
    logic [IDX_W-1:0] out_idx_q;
    logic signed [OUT_W-1:0] out_coef_q;

    // Handshake decisions for both input ports.
    assign blk_open  = (blk_cnt != '0);
    assign in_ready  = ~busy & ~go & (~out_valid_q | out_ready);
    assign ld_ready  = ~busy & ~go & ~pend & ~blk_open;
    assign in_acc    = in_valid & in_ready;
    assign ld_acc    = ld_valid & ld_ready;
    assign out_valid = out_valid_q;
    assign out_idx   = out_idx_q;
    assign out_coef  = out_coef_q;

    dq_prescale_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .blk_open  (blk_open),
        .go        (go),
        .busy      (busy),
        .pend      (pend),
        .done      (done),
        .wr_idx    (wr_idx)
    );

    dq_prescale_dp #(.Q_W(Q_W), .FRAC_X(FRAC_X), .PS_W(PS_W)) u_dp (
        .q   (raw_tab[wr_idx]),
        .row (wr_idx[IDX_W-1 -: AX_W]),
        .col (wr_idx[AX_W-1:0]),
        .ps  (ps_new)
    );

    dq_index_map u_map (
        .zz  (in_zz),
        .idx (in_idx),
        .nat (nat_idx)
    );

    dq_coef_mul #(.COEF_W(COEF_W), .PS_W(PS_W), .FRAC_X(FRAC_X), .OUT_W(OUT_W)) u_mul (
        .coef (in_coef),
        .ps   (ps_tab[nat_idx]),
        .res  (mul_res)
    );

    // Raw table: written only through the load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPOS; i++) raw_tab[i] <= '0;
        end else if (ld_acc) begin
            raw_tab[ld_addr] <= ld_q;
        end
    end

    // Prescaled table: one position written per prescale cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPOS; i++) ps_tab[i] <= '0;
        end else if (busy) begin
            ps_tab[wr_idx] <= ps_new;
        end
    end

    // Position within the current 64-coefficient block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (in_acc) begin
            blk_cnt <= (blk_cnt == LAST) ? '0 : blk_cnt + 1'b1;
        end
    end

    // Output register: loads on accept, clears when taken downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_idx_q   <= '0;
            out_coef_q  <= '0;
        end else if (in_acc) begin
            out_valid_q <= 1'b1;
            out_idx_q   <= nat_idx;
            out_coef_q  <= mul_res;
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_coef_q) && $stable(out_idx_q))); // R10
    AST_PASS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blk_cnt == '0)); // R8
    AST_LOAD_NOT_BEFORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_acc |=> !busy); // R1
    AST_CLOSE_THEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && blk_cnt == LAST) |=> (blk_cnt == '0)); // R7
endmodule

// File: tb/tb_dq_prescale_table.sv
`timescale 1ns/1ps
module tb_dq_prescale_table;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic ld_ready;
    logic [5:0] ld_addr = '0;
    logic [7:0] ld_q = '0;
    logic start_req = 1'b0;
    logic done;
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_zz = 1'b0;
    logic [5:0] in_idx = '0;
    logic signed [11:0] in_coef = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [5:0] out_idx;
    logic signed [15:0] out_coef;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit stall_on = 0;
    logic [15:0] rdy_lfsr = 16'hACE1;

    int fac [8] = '{16384, 22725, 21407, 19266, 16384, 12873, 8867, 4520};
    int zz_nat [64];
    int tb_raw [64];
    longint tb_ps [64];
    int exp_v [$];
    int exp_i [$];
    string exp_t [$];

    always #2.5 clk = ~clk;

    dq_prescale_table dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_q(ld_q),
        .start_req(start_req), .done(done),
        .in_valid(in_valid), .in_ready(in_ready), .in_zz(in_zz), .in_idx(in_idx), .in_coef(in_coef),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_coef(out_coef)
    );

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_ps(input int q, input int n);
        return (longint'(q) * fac[n / 8] * fac[n % 8] + (64'sd1 << 19)) >>> 20;
    endfunction

    function automatic int model_out(input int c, input longint p);
        longint v;
        v = (longint'(c) * p + 128) >>> 8;
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Downstream ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
        out_ready = stall_on ? rdy_lfsr[0] : 1'b1;
    end

    // Output monitor: order, values and hold while stalled (R10).
    bit prev_stall = 0;
    int prev_c = 0;
    int prev_i = 0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid && int'(out_coef) == prev_c && int'(out_idx) == prev_i,
                      "R10", "held beat", int'(out_coef), prev_c);
            end
            if (out_valid && out_ready) begin
                if (exp_v.size() == 0) begin
                    check(0, "R10", "unexpected beat", int'(out_coef), 0);
                end else begin
                    check(int'(out_coef) == exp_v[0], exp_t[0], "coefficient", int'(out_coef), exp_v[0]);
                    check(int'(out_idx) == exp_i[0], "R5", "natural index", int'(out_idx), exp_i[0]);
                    void'(exp_v.pop_front());
                    void'(exp_i.pop_front());
                    void'(exp_t.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_c = int'(out_coef);
            prev_i = int'(out_idx);
        end
    end

    task automatic load(input int a, input int q);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 6'(a); ld_q = 8'(q);
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        tb_raw[a] = q;
    endtask

    task automatic send(input int c, input int idx, input bit zz, input bit with_start, input string tag);
        int nat;
        @(negedge clk);
        ld_valid = 1'b0;
        in_valid = 1'b1; in_coef = 12'(c); in_idx = 6'(idx); in_zz = zz;
        start_req = with_start;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        nat = zz ? zz_nat[idx] : idx;
        exp_v.push_back(model_out(c, tb_ps[nat]));
        exp_i.push_back(nat);
        exp_t.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; ld_valid = 1'b0; start_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_v.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Start at a boundary, measure the stall window and the done pulse (R2, R9).
    task automatic prescale_run(input bit poke);
        int n_low;
        bit early_done;
        bit seen_done;
        bit bad;
        @(negedge clk);
        start_req = 1'b1;
        #1;
        check(!in_ready && !ld_ready, "R2", "ports closed at launch", in_ready, 0);
        n_low = 1; early_done = done; seen_done = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            start_req = poke && (i == 10);
            #1;
            if (in_ready) begin seen_done = done; break; end
            n_low++;
            if (done) early_done = 1;
        end
        @(negedge clk);
        start_req = 1'b0;
        #1;
        check(n_low == 65, "R2", "cycles with ready low", n_low, 65);
        check(seen_done && !early_done, "R2", "done on first free cycle", seen_done, 1);
        check(!done, "R2", "done lasts one cycle", done, 0);
        for (int n = 0; n < 64; n++) tb_ps[n] = model_ps(tb_raw[n], n);
        if (poke) begin
            bad = 0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk); #1;
                if (done || !in_ready) bad = 1;
            end
            check(!bad, "R9", "no second pass after busy start", bad, 0);
        end
    endtask

    initial begin
        int pos;
        int c;
        logic [15:0] lf;
        bit got_done;
        bit bad;

        pos = 0;
        for (int s = 0; s < 15; s++) begin
            if (s % 2 == 1) begin
                for (int r = (s > 7 ? s - 7 : 0); r <= (s < 7 ? s : 7); r++) begin zz_nat[pos] = r * 8 + (s - r); pos++; end
            end else begin
                for (int r = (s < 7 ? s : 7); r >= (s > 7 ? s - 7 : 0); r--) begin zz_nat[pos] = r * 8 + (s - r); pos++; end
            end
        end
        for (int n = 0; n < 64; n++) begin tb_raw[n] = 0; tb_ps[n] = 0; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11 reset state
        check(!out_valid, "R11", "out_valid after reset", out_valid, 0);
        check(!done, "R11", "done after reset", done, 0);
        check(in_ready, "R11", "in_ready after reset", in_ready, 1);
        check(ld_ready, "R11", "ld_ready after reset", ld_ready, 1);

        // R1 load first table, R2/R9 prescale with a start poked mid-pass
        for (int n = 0; n < 64; n++) load(n, ((n * 53 + 7) % 255) + 1);
        idle();
        prescale_run(1);

        // R3/R4 natural order, small coefficients
        for (int n = 0; n < 64; n++) send(((n * 29) % 61) - 30, n, 0, 0, "R4");
        idle(); drain();

        // R5/R6 zigzag order, extreme coefficients, downstream stalls
        stall_on = 1;
        for (int z = 0; z < 64; z++) send((z % 2 == 0) ? 2047 : -2048, z, 1, 0, "R6");
        idle(); drain();

        // R3 permuted natural order with pseudo-random coefficients; R7 probe
        lf = 16'h1D2B;
        for (int k = 0; k < 64; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            c = int'(lf[11:0]) - 2048;
            send(c, (k * 5 + 3) % 64, 0, 0, "R3");
            if (k == 20) begin
                @(negedge clk);
                in_valid = 1'b0; ld_valid = 1'b1; ld_addr = 6'd9; ld_q = 8'd1;
                bad = 0;
                for (int i = 0; i < 6; i++) begin #1; if (ld_ready) bad = 1; @(negedge clk); end
                ld_valid = 1'b0;
                check(!bad, "R7", "load held off mid-block", bad, 0);
            end
        end
        idle(); drain();
        stall_on = 0;

        // R1 second raw table: prescaled entries unchanged until next pass
        for (int n = 0; n < 64; n++) load(n, 255 - n * 3);
        idle();
        // R8 start raised with the 64th coefficient; that beat uses the old table
        for (int n = 0; n < 64; n++) send(256, n, 0, n == 63, "R8");
        idle();
        got_done = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (done) begin got_done = 1; break; end
        end
        check(got_done, "R8", "held start ran at boundary", got_done, 1);
        for (int n = 0; n < 64; n++) tb_ps[n] = model_ps(tb_raw[n], n);
        drain();

        // R8 next block uses the new table
        for (int z = 0; z < 64; z++) send((z % 7) * 37 - 100, z, 1, 0, "R8");
        idle(); drain();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200_000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule